// File: doc/BRIEF.md
# Sequential Booth Recoded Multiplier

This block multiplies two signed two's complement operands over several clock cycles. Each cycle it handles one bit of the multiplier: it compares that bit with the bit below it and then adds the multiplicand to the accumulator, subtracts it, or leaves the accumulator alone. After that it shifts the accumulator, the multiplier register and a one-bit history register right by one place, keeping the sign. Positive and negative multipliers go through exactly the same steps, so no sign correction is needed at the end.

A caller raises `start_i` for one cycle while the block is not busy. The block then runs `WIDTH` iterations, raises `done_o` for one cycle and holds the full-width product until the next accepted start. The accumulator is one bit wider than the operands internally, which keeps the most negative times most negative case exact.

Top module: `booth_seq_mul`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and `product_o` is 0.
- R2: A start seen at a rising edge while `busy_o` is 0 loads the operands, and `busy_o` is then high for exactly `WIDTH` consecutive cycles. The sign of either operand does not change this count.
- R3: `done_o` is high for exactly one cycle. That cycle immediately follows the last busy cycle, and `busy_o` is 0 during it.
- R4: While `done_o` is high, `product_o` equals the signed product of `a_i` and `b_i` as sampled at the accepted start, in 2*`WIDTH`-bit two's complement. The value holds until the next start is accepted.
- R5: Each multiplier bit is recoded against the bit to its right, and the position below the LSB counts as 0. Pair (bit,right) = (0,1) adds the multiplicand, (1,0) subtracts it, and equal bits do nothing. Multipliers with alternating bits, such as 0x55 and 0xAA, must still give exact products.
- R6: A start that arrives while `busy_o` is high is ignored. Operands presented with it have no effect on the running product.
- R7: Extreme operands give exact results. This includes -2^(WIDTH-1) times -2^(WIDTH-1), which gives +2^(2*WIDTH-2), as well as combinations with +2^(WIDTH-1)-1, 0 and -1.
- R8: For 11 times -13, the product is -143.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin a multiplication |
| a_i | input | WIDTH | Multiplicand, two's complement |
| b_i | input | WIDTH | Multiplier, two's complement |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 2*WIDTH | Signed product, {accumulator, multiplier register} |

## Verification
The bench targets the operand pair -128 times -128. A design with an accumulator only `WIDTH` bits wide overflows on this pair and returns a negative value. It also uses multipliers with alternating bits and long runs of ones, where swapping the add and subtract cases or seeding the history bit with 1 gives products that are off by multiples of the multiplicand. It fires start pulses with different operands in the middle of a run: a design that reloads on them reports the wrong product or stretches `busy_o`. A start placed in the done cycle, and a long random sweep, exercise the iteration count, the length of the done pulse and the holding of the result.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic      cur_i,
  input  logic      prev_i,
  output booth_op_e op_o
);
  always_comb begin
    unique case ({cur_i, prev_i})
      2'b01:   op_o = OP_ADD;
      2'b10:   op_o = OP_SUB;
      default: op_o = OP_NONE;
    endcase
  end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = WIDTH + 1
) (
  input  logic [AW-1:0]    acc_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  booth_op_e        op_i,
  output logic [AW-1:0]    sum_o
);
  logic [AW-1:0] mext;
  logic [AW-1:0] operand;
  logic          cin;

  assign mext = {mcand_i[WIDTH-1], mcand_i};

  // subtract as add of inverted operand plus carry-in
  always_comb begin
    unique case (op_i)
      OP_ADD:  begin operand = mext;        cin = 1'b0; end
      OP_SUB:  begin operand = ~mext;       cin = 1'b1; end
      default: begin operand = '0;          cin = 1'b0; end
    endcase
  end

  assign sum_o = acc_i + operand + AW'(cin);
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned CW = (WIDTH > 1) ? $clog2(WIDTH) : 1,
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign busy_o = (state_q == ST_RUN);
  assign done_o = (state_q == ST_DONE);
  assign step_o = busy_o;
  assign load_o = start_i && !busy_o;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        state_d = ST_IDLE;
        if (start_i) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end
      end
      ST_RUN: begin
        if (cnt_q == LAST) state_d = ST_DONE;
        else               cnt_d   = cnt_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R3
  AST_DONE_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o)); // R3
  AST_ITER_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(cnt_q) == LAST)); // R2
endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
  import booth_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = WIDTH + 1,
  localparam int unsigned PW = 2 * WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [PW-1:0]    product_o
);
  logic [AW-1:0]    acc_q;
  logic [WIDTH-1:0] mplr_q;
  logic [WIDTH-1:0] mcand_q;
  logic             hist_q;
  logic             load, step;
  booth_op_e        op;
  logic [AW-1:0]    sum;

  booth_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  booth_recode u_recode (
    .cur_i (mplr_q[0]),
    .prev_i(hist_q),
    .op_o  (op)
  );

  booth_addsub #(.WIDTH(WIDTH)) u_addsub (
    .acc_i  (acc_q),
    .mcand_i(mcand_q),
    .op_i   (op),
    .sum_o  (sum)
  );

  // add/sub then arithmetic right shift of {acc, mplr, hist}
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      mplr_q  <= '0;
      mcand_q <= '0;
      hist_q  <= 1'b0;
    end else if (load) begin
      acc_q   <= '0;
      mplr_q  <= b_i;
      mcand_q <= a_i;
      hist_q  <= 1'b0;
    end else if (step) begin
      acc_q   <= {sum[AW-1], sum[AW-1:1]};
      mplr_q  <= {sum[0], mplr_q[WIDTH-1:1]};
      hist_q  <= mplr_q[0];
    end
  end

  assign product_o = {acc_q[WIDTH-1:0], mplr_q};

  AST_IGNORE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(mcand_q)); // R6
  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(product_o)); // R4
endmodule

// File: tb/booth_seq_mul_bench.sv
module booth_seq_mul_bench;
  localparam int W  = 8;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  a = '0, b = '0;
  logic          busy, done;
  logic [PW-1:0] prod;

  int vectors = 0;
  int errors  = 0;
  bit finished = 0;

  always #4 clk = ~clk; // 125 MHz

  booth_seq_mul #(.WIDTH(W)) u_booth_seq_mul (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .a_i(a), .b_i(b),
    .busy_o(busy), .done_o(done), .product_o(prod)
  );

  // behavioural reference
  bit     m_busy = 0, m_done = 0;
  int     m_cnt = 0;
  longint m_exp = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_exp = 0;
    end else if (!m_busy && start) begin
      m_busy = 1; m_done = 0; m_cnt = 0;
      m_exp = longint'($signed(a)) * longint'($signed(b));
    end else if (m_busy) begin
      m_cnt++;
      if (m_cnt == W) begin m_busy = 0; m_done = 1; end
    end else m_done = 0;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    check(busy == m_busy, "R2 busy", longint'(busy), longint'(m_busy));
    check(done == m_done, "R3 done", longint'(done), longint'(m_done));
    if (!m_busy)
      check(prod == m_exp[PW-1:0], "R4 product", longint'($signed(prod)), m_exp);
  end

  task automatic run_mul(input logic [W-1:0] x, input logic [W-1:0] y, input string req);
    longint e;
    e = longint'($signed(x)) * longint'($signed(y));
    @(negedge clk); a = x; b = y; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    check(prod == e[PW-1:0], req, longint'($signed(prod)), e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && prod == 0, "R1 reset", longint'(prod), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0 && prod == 0, "R1 after release", longint'(prod), 0);

    run_mul(8'd11, -8'sd13, "R8 11*-13");
    check($signed(prod) == -143, "R8 value", longint'($signed(prod)), -143);
    run_mul(8'h80, 8'h80, "R7 min*min");
    run_mul(8'h80, 8'h7f, "R7 min*max");
    run_mul(8'h7f, 8'h80, "R7 max*min");
    run_mul(8'h7f, 8'h7f, "R7 max*max");
    run_mul(8'hff, 8'hff, "R7 -1*-1");
    run_mul(8'h00, 8'h80, "R7 0*min");
    run_mul(8'h80, 8'h00, "R7 min*0");
    run_mul(8'h13, 8'h55, "R5 alt 0x55");
    run_mul(-8'sd7, 8'hAA, "R5 alt 0xAA");
    run_mul(8'h25, 8'hF0, "R5 run of ones");
    run_mul(8'h25, 8'h01, "R5 lsb only");

    // R6: starts mid-run with other operands are ignored
    @(negedge clk); a = 8'd9; b = -8'sd5; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (2) @(negedge clk);
    a = 8'h80; b = 8'h80; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); a = 8'h7f; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    check($signed(prod) == -45, "R6 ignored start", longint'($signed(prod)), -45);

    // start during the done cycle is accepted (R2, R3)
    a = 8'd3; b = 8'd4; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1, "R2 restart from done", longint'(busy), 1);
    while (!done) @(negedge clk);
    check($signed(prod) == 12, "R4 restart product", longint'($signed(prod)), 12);

    for (int i = 0; i < 400; i++) begin
      run_mul(W'($urandom), W'($urandom), "R4 random");
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end

    repeat (2) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vectors++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule